// File: doc/BRIEF.md
# Copyback data cache controller

A direct-mapped data cache controller of sixteen lines, each holding four 32-bit long words. Every line is invalid, valid or dirty, and each long word keeps its own dirty bit. The CPU side takes single-word reads and byte-enabled writes. A flag on each write picks copyback or write-through handling. Two line maintenance commands are taken on the same port: invalidate, which drops a line, and push, which writes a dirty line back and then drops it.

The memory side runs one transfer at a time: a four-word line fill, a line write that carries a per-word mask, or a single-word write with byte enables. Each transfer is held until the memory acknowledges it, however many cycles that takes. When a miss displaces a dirty line, the victim is copied into a buffer, the new line is fetched first, and the buffered words are written back afterwards. A separate snoop port lets another bus master read through the cache. In leave-dirty mode, a hit on a dirty line raises memory inhibit and supplies the cached word.

Top module: `cb_dcache`

## Requirements
- R1: After reset every line is invalid, `done_o` and `mem_req_o` are low, and no snoop is inhibited.
- R2: A read miss to an invalid or valid line issues one fill (`mem_op_o`=0) at the line-aligned address (bits 3:0 zero), returns the addressed word, and leaves the line valid.
- R3: A read miss to a dirty line issues the fill first and then a line write (`mem_op_o`=1) at the victim's own line address; the line ends valid.
- R4: A read hit returns the cached word one cycle after acceptance, with no memory transfer and no state change.
- R5: A copyback write miss fills the line, merges the enabled bytes, marks the written word dirty and leaves the line dirty; a dirty victim is written back after the fill.
- R6: A write-through write miss issues only a word write (`mem_op_o`=2) carrying the byte enables, and allocates nothing.
- R7: A copyback write hit updates the cache with no memory transfer and makes the line dirty.
- R8: A write-through write hit updates the cache and issues a word write; the line state and dirty bits do not change.
- R9: Invalidate drops the addressed line with no memory transfer; dirty data is lost.
- R10: Push on a dirty line issues a line write and then invalidates; on a valid line it only invalidates; on an invalid line it does nothing.
- R11: With `snp_keep_i` high, a snoop that hits a dirty line raises `snp_inh_o` and drives the addressed word on `snp_data_o`. Any other snoop leaves `snp_inh_o` low.
- R12: A memory request holds its operation, address and data stable until `mem_ack_i`, and `done_o` is a single-cycle pulse.
- R13: The mask of a line write (bit n for long word n) is exactly the set of words written by copyback since the line was filled. Write-through writes add no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU request, held until `done_o` |
| op_i | input | 2 | 0 read, 1 write, 2 invalidate, 3 push |
| wt_i | input | 1 | Write-through for this write |
| addr_i | input | 32 | Byte address, long-word aligned |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| done_o | output | 1 | Request complete pulse |
| rdata_o | output | 32 | Read data, valid with `done_o` |
| snp_vld_i | input | 1 | Snoop read present |
| snp_keep_i | input | 1 | Leave-dirty snoop mode |
| snp_addr_i | input | 30 | Snoop long-word address (bits 31:2) |
| snp_inh_o | output | 1 | Memory inhibit for snoop |
| snp_data_o | output | 32 | Snoop data when inhibiting |
| mem_req_o | output | 1 | Memory transfer request |
| mem_op_o | output | 2 | 0 fill, 1 line write, 2 word write |
| mem_addr_o | output | 32 | Transfer address |
| mem_wline_o | output | 128 | Line write data, word 0 in low bits |
| mem_wmask_o | output | 4 | Words valid in a line write |
| mem_wdata_o | output | 32 | Word write data |
| mem_be_o | output | 4 | Word write byte enables |
| mem_ack_i | input | 1 | Transfer complete |
| mem_rline_i | input | 128 | Fill data, valid with `mem_ack_i` |

## Verification
The assertions assume that `mem_ack_i` rises only while `mem_req_o` is high. They assume that `req_i` and its fields stay fixed until `done_o`, and that a write has at least one byte enable set. The bench's memory model raises the acknowledge only for a request it has seen, after a random wait of zero to three cycles. Its CPU driver holds every request until completion, then drops it. Write stimulus draws byte enables from 1 to 15, and snoops are issued only while the controller is idle.

// File: rtl/dc_pkg.sv
package dc_pkg;
  parameter int unsigned LINES = 16;
  parameter int unsigned WORDS = 4;
  parameter int unsigned DW    = 32;
  parameter int unsigned AW    = 32;

  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned OFF_W  = $clog2(WORDS);
  localparam int unsigned BE_W   = DW / 8;
  localparam int unsigned LINE_W = WORDS * DW;
  localparam int unsigned IDX_LO = OFF_W + 2;
  localparam int unsigned TAG_LO = IDX_LO + IDX_W;
  localparam int unsigned TAG_W  = AW - TAG_LO;

  typedef enum logic [1:0] {LS_INV, LS_VAL, LS_DIRTY} line_st_e;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_INV, OP_PUSH} cpu_op_e;
  typedef enum logic [1:0] {MEM_FILL, MEM_LWR, MEM_WWR} mem_op_e;

  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line,
                                                    input logic [OFF_W-1:0] w,
                                                    input logic [DW-1:0] d,
                                                    input logic [BE_W-1:0] be);
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < int'(BE_W); b++)
      if (be[b]) r[int'(w)*DW + b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [WORDS-1:0] word_mask(input logic [OFF_W-1:0] w,
                                                 input logic [BE_W-1:0] be);
    logic [WORDS-1:0] m;
    m = '0;
    m[w] = |be;
    return m;
  endfunction

  function automatic logic [DW-1:0] get_word(input logic [LINE_W-1:0] line,
                                             input logic [OFF_W-1:0] w);
    return line[int'(w)*DW +: DW];
  endfunction
endpackage

// File: rtl/dc_line_store.sv
module dc_line_store
  import dc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [TAG_W-1:0]  a_tag_o,
  output line_st_e          a_st_o,
  output logic [WORDS-1:0]  a_dirty_o,
  output logic [LINE_W-1:0] a_line_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [TAG_W-1:0]  b_tag_o,
  output line_st_e          b_st_o,
  output logic [LINE_W-1:0] b_line_o,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  w_tag_i,
  input  line_st_e          w_st_i,
  input  logic [WORDS-1:0]  w_dirty_i,
  input  logic [LINE_W-1:0] w_line_i
);
  line_st_e          st_q    [LINES];
  logic [WORDS-1:0]  dirty_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINE_W-1:0] line_q  [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(LINES); i++) begin
        st_q[i]    <= LS_INV;
        dirty_q[i] <= '0;
      end
    end else if (we_i) begin
      st_q[a_idx_i]    <= w_st_i;
      dirty_q[a_idx_i] <= w_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[a_idx_i]  <= w_tag_i;
      line_q[a_idx_i] <= w_line_i;
    end
  end

  assign a_tag_o   = tag_q[a_idx_i];
  assign a_st_o    = st_q[a_idx_i];
  assign a_dirty_o = dirty_q[a_idx_i];
  assign a_line_o  = line_q[a_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_st_o    = st_q[b_idx_i];
  assign b_line_o  = line_q[b_idx_i];

  // R13
  clean_no_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w_st_i != LS_DIRTY) |-> (w_dirty_i == '0));
endmodule

// File: rtl/dc_victim_buf.sv
module dc_victim_buf
  import dc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [WORDS-1:0]  mask_i,
  output logic              pend_o,
  output logic [AW-1:0]     addr_o,
  output logic [LINE_W-1:0] line_o,
  output logic [WORDS-1:0]  mask_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (load_i) pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      addr_o <= addr_i;
      line_o <= line_i;
      mask_o <= mask_i;
    end
  end

  assign pend_o = pend_q;

  // R3
  victim_no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pend_o);
endmodule

// File: rtl/cb_dcache.sv
module cb_dcache
  import dc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic              wt_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  input  logic              snp_vld_i,
  input  logic              snp_keep_i,
  input  logic [AW-1:2]     snp_addr_i,
  output logic              snp_inh_o,
  output logic [DW-1:0]     snp_data_o,
  output logic              mem_req_o,
  output logic [1:0]        mem_op_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [LINE_W-1:0] mem_wline_o,
  output logic [WORDS-1:0]  mem_wmask_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rline_i
);
  typedef enum logic [2:0] {S_IDLE, S_FILL, S_VWB, S_WT, S_PUSH} fsm_e;

  fsm_e            fsm_q, fsm_d;
  logic [AW-1:0]   r_addr;
  cpu_op_e         r_op;
  logic [DW-1:0]   r_wdata;
  logic [BE_W-1:0] r_be;
  logic            done_q, done_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            accept;

  logic [AW-1:0]    cur_addr;
  logic [IDX_W-1:0] cur_idx;
  logic [TAG_W-1:0] cur_tag;
  logic [OFF_W-1:0] cur_w;
  logic             hit;

  logic [TAG_W-1:0]  rd_tag, s_tag;
  line_st_e          rd_st, s_st;
  logic [WORDS-1:0]  rd_dirty;
  logic [LINE_W-1:0] rd_line, s_line;
  logic              st_we;
  logic [TAG_W-1:0]  st_tag;
  line_st_e          st_st;
  logic [WORDS-1:0]  st_dirty;
  logic [LINE_W-1:0] st_line;

  logic              vb_load, vb_clr, vb_pend;
  logic [AW-1:0]     vb_addr;
  logic [LINE_W-1:0] vb_line;
  logic [WORDS-1:0]  vb_mask;

  assign cur_addr = (fsm_q == S_IDLE) ? addr_i : r_addr;
  assign cur_idx  = cur_addr[TAG_LO-1:IDX_LO];
  assign cur_tag  = cur_addr[AW-1:TAG_LO];
  assign cur_w    = cur_addr[IDX_LO-1:2];
  assign hit      = (rd_st != LS_INV) && (rd_tag == cur_tag);

  dc_line_store i_store (
    .clk_i, .rst_ni,
    .a_idx_i(cur_idx), .a_tag_o(rd_tag), .a_st_o(rd_st), .a_dirty_o(rd_dirty), .a_line_o(rd_line),
    .b_idx_i(snp_addr_i[TAG_LO-1:IDX_LO]), .b_tag_o(s_tag), .b_st_o(s_st), .b_line_o(s_line),
    .we_i(st_we), .w_tag_i(st_tag), .w_st_i(st_st), .w_dirty_i(st_dirty), .w_line_i(st_line)
  );

  dc_victim_buf i_vbuf (
    .clk_i, .rst_ni,
    .load_i(vb_load), .clr_i(vb_clr),
    .addr_i({rd_tag, cur_idx, {IDX_LO{1'b0}}}), .line_i(rd_line), .mask_i(rd_dirty),
    .pend_o(vb_pend), .addr_o(vb_addr), .line_o(vb_line), .mask_o(vb_mask)
  );

  always_comb begin
    fsm_d    = fsm_q;
    accept   = 1'b0;
    done_d   = 1'b0;
    rdata_d  = rdata_q;
    st_we    = 1'b0;
    st_tag   = rd_tag;
    st_st    = rd_st;
    st_dirty = rd_dirty;
    st_line  = rd_line;
    vb_load  = 1'b0;
    vb_clr   = 1'b0;
    unique case (fsm_q)
      S_IDLE: if (req_i && !done_q) begin
        accept = 1'b1;
        unique case (cpu_op_e'(op_i))
          OP_RD: if (hit) begin
            rdata_d = get_word(rd_line, cur_w);
            done_d  = 1'b1;
          end else begin
            vb_load = (rd_st == LS_DIRTY);
            fsm_d   = S_FILL;
          end
          OP_WR: if (wt_i) begin
            st_we   = hit;
            st_line = merge_word(rd_line, cur_w, wdata_i, be_i);
            fsm_d   = S_WT;
          end else if (hit) begin
            st_we    = 1'b1;
            st_line  = merge_word(rd_line, cur_w, wdata_i, be_i);
            st_dirty = rd_dirty | word_mask(cur_w, be_i);
            st_st    = LS_DIRTY;
            done_d   = 1'b1;
          end else begin
            vb_load = (rd_st == LS_DIRTY);
            fsm_d   = S_FILL;
          end
          OP_INV: begin
            st_we    = 1'b1;
            st_st    = LS_INV;
            st_dirty = '0;
            done_d   = 1'b1;
          end
          OP_PUSH: if (rd_st == LS_DIRTY) begin
            fsm_d = S_PUSH;
          end else begin
            st_we    = 1'b1;
            st_st    = LS_INV;
            st_dirty = '0;
            done_d   = 1'b1;
          end
          default: ;
        endcase
      end
      S_FILL: if (mem_ack_i) begin
        st_we   = 1'b1;
        st_tag  = cur_tag;
        rdata_d = get_word(mem_rline_i, cur_w);
        if (r_op == OP_WR) begin
          st_line  = merge_word(mem_rline_i, cur_w, r_wdata, r_be);
          st_st    = LS_DIRTY;
          st_dirty = word_mask(cur_w, r_be);
        end else begin
          st_line  = mem_rline_i;
          st_st    = LS_VAL;
          st_dirty = '0;
        end
        if (vb_pend) fsm_d = S_VWB;
        else begin
          fsm_d  = S_IDLE;
          done_d = 1'b1;
        end
      end
      S_VWB: if (mem_ack_i) begin
        vb_clr = 1'b1;
        fsm_d  = S_IDLE;
        done_d = 1'b1;
      end
      S_WT: if (mem_ack_i) begin
        fsm_d  = S_IDLE;
        done_d = 1'b1;
      end
      S_PUSH: if (mem_ack_i) begin
        st_we    = 1'b1;
        st_st    = LS_INV;
        st_dirty = '0;
        fsm_d    = S_IDLE;
        done_d   = 1'b1;
      end
      default: fsm_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= S_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
      r_addr  <= '0;
      r_op    <= OP_RD;
      r_wdata <= '0;
      r_be    <= '0;
    end else begin
      fsm_q   <= fsm_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
      if (accept) begin
        r_addr  <= addr_i;
        r_op    <= cpu_op_e'(op_i);
        r_wdata <= wdata_i;
        r_be    <= be_i;
      end
    end
  end

  always_comb begin
    mem_op_o   = MEM_FILL;
    mem_addr_o = {cur_tag, cur_idx, {IDX_LO{1'b0}}};
    unique case (fsm_q)
      S_VWB:   begin mem_op_o = MEM_LWR; mem_addr_o = vb_addr; end
      S_PUSH:  begin mem_op_o = MEM_LWR; mem_addr_o = {rd_tag, cur_idx, {IDX_LO{1'b0}}}; end
      S_WT:    begin mem_op_o = MEM_WWR; mem_addr_o = r_addr; end
      default: ;
    endcase
  end

  assign mem_req_o   = (fsm_q != S_IDLE);
  assign mem_wline_o = (fsm_q == S_VWB) ? vb_line : rd_line;
  assign mem_wmask_o = (fsm_q == S_VWB) ? vb_mask : (fsm_q == S_PUSH) ? rd_dirty : '0;
  assign mem_wdata_o = r_wdata;
  assign mem_be_o    = (fsm_q == S_WT) ? r_be : '0;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;

  assign snp_inh_o  = snp_vld_i && snp_keep_i && (s_st == LS_DIRTY) &&
                      (s_tag == snp_addr_i[AW-1:TAG_LO]);
  assign snp_data_o = get_word(s_line, snp_addr_i[IDX_LO-1:2]);

  // R12
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_op_o)));
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  wb_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == S_VWB && $past(fsm_q) != S_VWB) |-> ($past(fsm_q) == S_FILL));
  // R12
  no_done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);
endmodule

// File: tb/test_cb_dcache.sv
module test_cb_dcache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wt = 1'b0;
  logic [1:0] op = '0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0] be = '0;
  logic done;
  logic [31:0] rdata;
  logic snp_vld = 1'b0, snp_keep = 1'b0;
  logic [31:2] snp_addr = '0;
  logic snp_inh;
  logic [31:0] snp_data;
  logic mem_req, mem_ack;
  logic [1:0] mem_op;
  logic [31:0] mem_addr, mem_wdata;
  logic [127:0] mem_wline, mem_rline;
  logic [3:0] mem_wmask, mem_be;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] bmem [256];
  logic [31:0] mm [256];
  int m_st [16];
  logic [23:0] m_tag [16];
  logic [3:0] m_dirty [16];
  logic [31:0] m_data [16][4];

  logic [1:0] lg_op [4];
  logic [31:0] lg_addr [4];
  logic [3:0] lg_mask [4];
  int lg_n;
  logic [1:0] e_op [4];
  logic [31:0] e_addr [4];
  logic [3:0] e_mask [4];
  int exp_n;
  logic [31:0] exp_rd;
  string exp_req;

  logic [1:0] q_op;
  logic [31:0] q_a;
  int q_d;

  cb_dcache i_cb_dcache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .wt_i(wt), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .done_o(done), .rdata_o(rdata),
    .snp_vld_i(snp_vld), .snp_keep_i(snp_keep), .snp_addr_i(snp_addr),
    .snp_inh_o(snp_inh), .snp_data_o(snp_data),
    .mem_req_o(mem_req), .mem_op_o(mem_op), .mem_addr_o(mem_addr), .mem_wline_o(mem_wline),
    .mem_wmask_o(mem_wmask), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_ack_i(mem_ack), .mem_rline_i(mem_rline)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d, input logic [3:0] b);
    for (int k = 0; k < 4; k++) if (b[k]) o[k*8 +: 8] = d[k*8 +: 8];
    return o;
  endfunction

  function automatic logic [31:0] adr(input int t, input int i, input int w);
    return {22'd0, t[1:0], i[3:0], w[1:0], 2'b00};
  endfunction

  // memory model: random latency, logs every transfer
  initial begin
    mem_ack = 1'b0;
    mem_rline = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        q_op = mem_op;
        q_a = mem_addr;
        q_d = $urandom_range(0, 3);
        repeat (q_d) @(negedge clk);
        chk("R12 request held", {31'd0, mem_req}, 32'd1);
        chk("R12 address held", mem_addr, q_a);
        case (q_op)
          2'd0: for (int k = 0; k < 4; k++) mem_rline[k*32 +: 32] = bmem[q_a[9:2] + 8'(k)];
          2'd1: for (int k = 0; k < 4; k++)
                  if (mem_wmask[k]) bmem[q_a[9:2] + 8'(k)] = mem_wline[k*32 +: 32];
          default: bmem[q_a[9:2]] = mrg(bmem[q_a[9:2]], mem_wdata, mem_be);
        endcase
        if (lg_n < 4) begin
          lg_op[lg_n] = q_op;
          lg_addr[lg_n] = q_a;
          lg_mask[lg_n] = (q_op == 2'd1) ? mem_wmask : (q_op == 2'd2) ? mem_be : 4'd0;
        end
        lg_n++;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic add_exp(input logic [1:0] o, input logic [31:0] a, input logic [3:0] m);
    e_op[exp_n] = o;
    e_addr[exp_n] = a;
    e_mask[exp_n] = m;
    exp_n++;
  endtask

  task automatic victim_out(input int i);
    logic [31:0] va;
    va = {m_tag[i], i[3:0], 4'b0};
    add_exp(2'd1, va, m_dirty[i]);
    for (int k = 0; k < 4; k++) if (m_dirty[i][k]) mm[va[9:2] + 8'(k)] = m_data[i][k];
  endtask

  task automatic model_step(input logic [1:0] o, input logic w_t, input logic [31:0] a,
                            input logic [31:0] wd, input logic [3:0] b);
    int i, w;
    logic [23:0] tg;
    bit hit, vd;
    i = int'(a[7:4]);
    w = int'(a[3:2]);
    tg = a[31:8];
    hit = (m_st[i] != 0) && (m_tag[i] == tg);
    vd = (m_st[i] == 2);
    exp_n = 0;
    exp_rd = '0;
    case (o)
      2'd0, 2'd1: begin
        if (o == 2'd1 && w_t) begin
          exp_req = hit ? "R8" : "R6";
          if (hit) m_data[i][w] = mrg(m_data[i][w], wd, b);
          add_exp(2'd2, a, b);
          mm[a[9:2]] = mrg(mm[a[9:2]], wd, b);
        end else if (hit) begin
          if (o == 2'd0) begin
            exp_req = "R4";
            exp_rd = m_data[i][w];
          end else begin
            exp_req = "R7";
            m_data[i][w] = mrg(m_data[i][w], wd, b);
            m_dirty[i][w] = 1'b1;
            m_st[i] = 2;
          end
        end else begin
          exp_req = (o == 2'd1) ? "R5" : vd ? "R3" : "R2";
          add_exp(2'd0, {tg, i[3:0], 4'b0}, 4'd0);
          if (vd) victim_out(i);
          for (int k = 0; k < 4; k++) m_data[i][k] = mm[{tg[1:0], i[3:0], k[1:0]}];
          m_tag[i] = tg;
          if (o == 2'd0) begin
            exp_rd = m_data[i][w];
            m_st[i] = 1;
            m_dirty[i] = '0;
          end else begin
            m_data[i][w] = mrg(m_data[i][w], wd, b);
            m_dirty[i] = '0;
            m_dirty[i][w] = 1'b1;
            m_st[i] = 2;
          end
        end
      end
      2'd2: begin
        exp_req = "R9";
        m_st[i] = 0;
        m_dirty[i] = '0;
      end
      default: begin
        exp_req = "R10";
        if (vd) victim_out(i);
        m_st[i] = 0;
        m_dirty[i] = '0;
      end
    endcase
  endtask

  task automatic do_op(input logic [1:0] o, input logic w_t, input logic [31:0] a,
                       input logic [31:0] wd, input logic [3:0] b);
    int cyc;
    logic [31:0] got;
    model_step(o, w_t, a, wd, b);
    lg_n = 0;
    @(negedge clk);
    req = 1'b1; op = o; wt = w_t; addr = a; wdata = wd; be = b;
    cyc = 0;
    forever begin
      @(negedge clk);
      if (done || cyc > 200) break;
      cyc++;
    end
    got = rdata;
    req = 1'b0;
    chk({exp_req, " completion"}, {31'd0, done}, 32'd1);
    chk({exp_req, " transfer count"}, lg_n, exp_n);
    for (int j = 0; j < exp_n && j < lg_n && j < 4; j++) begin
      chk({exp_req, " transfer op"}, {30'd0, lg_op[j]}, {30'd0, e_op[j]});
      chk({exp_req, " transfer addr"}, lg_addr[j], e_addr[j]);
      chk((e_op[j] == 2'd1) ? "R13 line mask" : {exp_req, " byte enables"},
          {28'd0, lg_mask[j]}, {28'd0, e_mask[j]});
    end
    if (o == 2'd0) chk({exp_req, " read data"}, got, exp_rd);
  endtask

  task automatic snoop(input logic [31:0] a, input logic k, input logic v);
    bit e_inh;
    int i;
    i = int'(a[7:4]);
    e_inh = v && k && (m_st[i] == 2) && (m_tag[i] == a[31:8]);
    @(negedge clk);
    snp_vld = v; snp_keep = k; snp_addr = a[31:2];
    #1;
    chk("R11 inhibit", {31'd0, snp_inh}, {31'd0, e_inh});
    if (e_inh) chk("R11 snoop data", snp_data, m_data[i][int'(a[3:2])]);
    snp_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    lg_n = 0;
    for (int k = 0; k < 256; k++) begin
      bmem[k] = k * 32'h9E3779B1 + 32'h1357;
      mm[k] = bmem[k];
    end
    for (int i = 0; i < 16; i++) begin
      m_st[i] = 0; m_tag[i] = '0; m_dirty[i] = '0;
      for (int k = 0; k < 4; k++) m_data[i][k] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 no memory request", {31'd0, mem_req}, 32'd0);
    snoop(adr(0, 3, 1), 1'b1, 1'b1);

    // directed corner cases
    do_op(2'd0, 0, adr(0, 1, 2), 0, 0);                     // R2 clean miss
    do_op(2'd0, 0, adr(0, 1, 3), 0, 0);                     // R4 hit
    do_op(2'd1, 0, adr(0, 1, 1), 32'hA5A5_1234, 4'b0101);   // R7
    snoop(adr(0, 1, 1), 1'b1, 1'b1);                        // R11 inhibit
    snoop(adr(0, 1, 1), 1'b0, 1'b1);                        // R11 not leave-dirty
    snoop(adr(0, 1, 1), 1'b1, 1'b0);
    do_op(2'd0, 0, adr(2, 1, 0), 0, 0);                     // R3 dirty victim
    do_op(2'd1, 0, adr(1, 2, 3), 32'h0BAD_F00D, 4'b1111);   // R5 clean victim
    do_op(2'd1, 0, adr(3, 2, 0), 32'h1111_2222, 4'b0011);   // R5 dirty victim
    do_op(2'd1, 1, adr(1, 5, 0), 32'hCAFE_0000, 4'b1100);   // R6
    do_op(2'd0, 0, adr(1, 5, 0), 0, 0);                     // R6 no allocate
    do_op(2'd1, 0, adr(1, 5, 2), 32'h7777_8888, 4'b1000);   // R7
    do_op(2'd1, 1, adr(1, 5, 1), 32'h3333_4444, 4'b1111);   // R8 on dirty
    do_op(2'd3, 0, adr(1, 5, 0), 0, 0);                     // R10 dirty, R13 mask
    do_op(2'd3, 0, adr(1, 5, 0), 0, 0);                     // R10 invalid
    do_op(2'd0, 0, adr(0, 6, 0), 0, 0);
    do_op(2'd1, 1, adr(0, 6, 2), 32'h5555_6666, 4'b0001);   // R8 on valid
    do_op(2'd3, 0, adr(0, 6, 0), 0, 0);                     // R10 valid
    do_op(2'd1, 0, adr(0, 7, 1), 32'hDEAD_BEEF, 4'b1111);
    do_op(2'd2, 0, adr(0, 7, 0), 0, 0);                     // R9 dirty lost
    do_op(2'd0, 0, adr(0, 7, 1), 0, 0);

    for (int n = 0; n < 600; n++) begin
      int r;
      logic [31:0] a;
      r = $urandom_range(0, 99);
      a = adr($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 3));
      if (r < 40)      do_op(2'd0, 0, a, 0, 0);
      else if (r < 80) do_op(2'd1, ($urandom_range(0, 9) < 3), a, $urandom, 4'($urandom_range(1, 15)));
      else if (r < 90) do_op(2'd2, 0, a, 0, 0);
      else             do_op(2'd3, 0, a, 0, 0);
      if ($urandom_range(0, 1) == 1)
        snoop(adr($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule